// File: doc/BRIEF.md
# Pin Register Slave for a Split-Phase Control-Register Bus

This block sits on a processor's control-register extension bus and owns two registers: a writable output-pin register whose bits drive `pins_out`, and a read-only input-pin register that reflects the `pins_in` pads after a two-flop synchroniser. A bus access takes two cycles. In the first cycle only the 12-bit address is presented and the slave decodes it into a registered hit flag. In the second cycle the bus presents the read strobe, the modify code and the write data. The slave acts on the hit from the first cycle.

Writes are read-modify operations on the whole register: replace, OR-in or clear-bits. A read returns the register content from before any modify in the same cycle. The slave answers only for its own two addresses. For every other address, and whenever no read is requested, `valid` and `rdata` stay at zero.

Top module: `csr_pin_slave`

## Requirements
- R1: While reset is held and in the first cycle after it, `pins_out` is 0, `valid` is 0 and `rdata` is 0.
- R2: If the address in cycle t is 0xBC1 and `read` is 1 in cycle t+1, then in cycle t+1 `valid` is 1 and `rdata` holds the output-pin register.
- R3: `valid` is 1 only in a cycle where `read` is 1 and the previous cycle's address is 0xBC1 or 0xFC1. When `valid` is 0, `rdata` is 0.
- R4: Modify code 3'b001 in the data cycle of an access to 0xBC1 makes the register equal `wdata` from the next cycle on.
- R5: Modify code 3'b010 on 0xBC1 ORs `wdata` into the register.
- R6: Modify code 3'b011 on 0xBC1 clears every register bit that is 1 in `wdata`.
- R7: Modify codes 3'b000 and 3'b100 to 3'b111 leave the output-pin register unchanged.
- R8: A modify with a previous-cycle address other than 0xBC1 leaves the output-pin register unchanged.
- R9: A read at 0xFC1 returns `pins_in` delayed by two clock edges. A change applied just before an address cycle is not yet visible in the data cycle that follows. It is visible one access later.
- R10: Modify operations aimed at 0xFC1 change neither the input-pin register nor the output-pin register.
- R11: A read combined with a modify in the same data cycle returns the value from before the modify.
- R12: Decode uses only the address of the previous cycle. The address present during the data cycle has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 12 | Register address, one cycle ahead of the data phase |
| read | input | 1 | Read strobe of the data phase |
| modify | input | 3 | Modify code: 001 write, 010 set, 011 clear, others none |
| wdata | input | 32 | Operand of the modify operation |
| rdata | output | 32 | Read data, zero unless `valid` is 1 |
| valid | output | 1 | The slave owns the decoded address and a read is active |
| pins_in | input | WIDTH | Asynchronous input pads |
| pins_out | output | WIDTH | Output-pin register |

## Verification
The hardest case to reach is a data cycle whose own address points at one register while the decoded address from the previous cycle points at the other, or at neither. An off-by-one in the decode pipeline would only show up there. Every bench access therefore drives an unrelated address, often one of the two owned addresses, during its data phase. Random sequences mix reads with modifies in the same cycle. A directed sequence changes `pins_in` right at an address cycle, which exposes the synchroniser latency.

// File: rtl/csr_pin_slave.sv
module csr_pin_slave #(
  parameter int          WIDTH    = 32,
  parameter logic [11:0] OUT_ADDR = 12'hBC1,
  parameter logic [11:0] IN_ADDR  = 12'hFC1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [11:0]      addr,
  input  logic             read,
  input  logic [2:0]       modify,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             valid,
  input  logic [WIDTH-1:0] pins_in,
  output logic [WIDTH-1:0] pins_out
);

  logic             hit_out_q, hit_in_q;
  logic [WIDTH-1:0] sync_a, sync_b, out_q, next_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_out_q <= 1'b0;
      hit_in_q  <= 1'b0;
      sync_a    <= '0;
      sync_b    <= '0;
      out_q     <= '0;
    end else begin
      hit_out_q <= (addr == OUT_ADDR);
      hit_in_q  <= (addr == IN_ADDR);
      sync_a    <= pins_in;
      sync_b    <= sync_a;
      if (hit_out_q) out_q <= next_out;
    end
  end

  always_comb begin
    case (modify)
      3'b001:  next_out = wdata[WIDTH-1:0];
      3'b010:  next_out = out_q | wdata[WIDTH-1:0];
      3'b011:  next_out = out_q & ~wdata[WIDTH-1:0];
      default: next_out = out_q;
    endcase
  end

  assign valid    = read & (hit_out_q | hit_in_q);
  assign rdata    = !read    ? 32'd0 :
                    hit_out_q ? 32'(out_q) :
                    hit_in_q  ? 32'(sync_b) : 32'd0;
  assign pins_out = out_q;

endmodule

// File: rtl/csr_pin_slave_chk.sv
module csr_pin_slave_chk #(
  parameter int          WIDTH    = 32,
  parameter logic [11:0] OUT_ADDR = 12'hBC1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [11:0]      addr,
  input logic             read,
  input logic [2:0]       modify,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic             valid,
  input logic [WIDTH-1:0] pins_out
);

  logic sel_o;
  always_ff @(posedge clk) begin
    if (!rst_n) sel_o <= 1'b0;
    else        sel_o <= (addr == OUT_ADDR);
  end

  assert_valid_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> read);
  assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> rdata == 32'd0);
  assert_out_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o && read) |-> (valid && rdata == 32'(pins_out)));
  assert_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o && modify == 3'b001) |=> pins_out == $past(wdata[WIDTH-1:0]));
  assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o && modify == 3'b010) |=> pins_out == ($past(pins_out) | $past(wdata[WIDTH-1:0])));
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o && modify == 3'b011) |=> pins_out == ($past(pins_out) & ~$past(wdata[WIDTH-1:0])));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_o && (modify == 3'b001 || modify == 3'b010 || modify == 3'b011)) |=> $stable(pins_out));

endmodule

bind csr_pin_slave csr_pin_slave_chk #(.WIDTH(WIDTH), .OUT_ADDR(OUT_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .read(read), .modify(modify),
  .wdata(wdata), .rdata(rdata), .valid(valid), .pins_out(pins_out)
);

// File: tb/csr_pin_slave_tb_top.sv
module csr_pin_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] OA = 12'hBC1;
  localparam logic [11:0] IA = 12'hFC1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic read = 1'b0;
  logic [2:0] modify = '0;
  logic [31:0] wdata = '0, rdata, pins_in = '0, pins_out;
  logic valid;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_out = '0, exp_in = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_pin_slave dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .read(read),
    .modify(modify), .wdata(wdata), .rdata(rdata), .valid(valid),
    .pins_in(pins_in), .pins_out(pins_out));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] apply_mod(logic [31:0] cur, logic [2:0] m, logic [31:0] w);
    case (m)
      3'b001: return w;
      3'b010: return cur | w;
      3'b011: return cur & ~w;
      default: return cur;
    endcase
  endfunction

  function automatic string mod_tag(logic [11:0] a, logic [2:0] m);
    if (a == IA) return "R10";
    if (a != OA) return "R8";
    case (m)
      3'b001: return "R4";
      3'b010: return "R5";
      3'b011: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic access(logic [11:0] a, logic rd, logic [2:0] m, logic [31:0] w, logic [11:0] junk);
    logic ev;
    logic [31:0] er;
    @(negedge clk);
    addr = a; read = 1'b0; modify = 3'b000;
    @(negedge clk);
    addr = junk; read = rd; modify = m; wdata = w;
    #1;
    ev = rd && (a == OA || a == IA);
    er = !ev ? 32'd0 : (a == OA ? exp_out : exp_in);
    check((a == OA && m != 0) ? "R11" : (junk != a ? "R12" : "R2"), {31'd0, valid}, {31'd0, ev});
    check(a == IA ? "R9" : (ev ? "R2" : "R3"), rdata, er);
    if (a == OA) exp_out = apply_mod(exp_out, m, w);
    @(negedge clk);
    addr = 12'h000; read = 1'b0; modify = 3'b000;
    check(mod_tag(a, m), pins_out, exp_out);
  endtask

  task automatic set_pins(logic [31:0] v);
    @(negedge clk);
    pins_in = v;
    repeat (3) @(negedge clk);
    exp_in = v;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", pins_out, 32'd0);
    check("R1", {31'd0, valid}, 32'd0);
    check("R1", rdata, 32'd0);
    rst_n = 1'b1;
    #1;
    check("R1", pins_out, 32'd0);
    access(OA, 1, 3'b000, 32'hFFFF_FFFF, IA);

    access(OA, 1, 3'b001, 32'hA5A5_0F0F, IA);
    access(OA, 1, 3'b010, 32'h0000_F0F0, 12'h000);
    access(OA, 1, 3'b011, 32'hA000_00FF, OA);
    for (int m = 4; m < 8; m++) access(OA, 1, 3'(m), 32'h1234_5678, OA);
    access(OA, 0, 3'b000, 32'hFFFF_FFFF, OA);
    access(12'hBC0, 1, 3'b001, 32'hDEAD_BEEF, OA);
    access(12'h3C1, 1, 3'b010, 32'hFFFF_FFFF, OA);
    set_pins(32'h5A5A_C3C3);
    access(IA, 1, 3'b001, 32'h0, OA);
    access(IA, 1, 3'b011, 32'hFFFF_FFFF, IA);
    access(IA, 1, 3'b000, 32'h0, IA);
    access(OA, 1, 3'b000, 32'h0, IA);
    access(12'h123, 0, 3'b001, 32'h0, OA);
    access(12'h123, 1, 3'b000, 32'h0, OA);

    @(negedge clk);
    pins_in = 32'h0F0F_1111; addr = IA; read = 1'b0;
    @(negedge clk);
    read = 1'b1; addr = 12'h000; #1;
    check("R9", rdata, exp_in);
    @(negedge clk);
    read = 1'b0; addr = IA;
    @(negedge clk);
    read = 1'b1; addr = 12'h000; #1;
    exp_in = 32'h0F0F_1111;
    check("R9", rdata, exp_in);
    @(negedge clk);
    read = 1'b0;

    for (int i = 0; i < 400; i++) begin
      logic [11:0] a, j;
      int sel = $urandom_range(0, 3);
      a = sel == 0 ? OA : sel == 1 ? IA : sel == 2 ? 12'($urandom) : OA;
      j = $urandom_range(0, 1) ? OA : IA;
      if ($urandom_range(0, 15) == 0) set_pins($urandom);
      access(a, 1'($urandom), 3'($urandom), $urandom, j);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule